// File: doc/BRIEF.md
# Serial Link Write Transaction Sequencer

This block drives the initiating side of a byte-oriented, full-duplex serial link and carries out one complete write transaction towards a responding node each time it is started. It opens the exchange with an interrupt request, transmits an eight-byte header that describes the target location and the number of values, then transmits a block of up to `DATA_MAX` data nibbles and closes the exchange with an end-of-transmission code. After each frame it waits for the responder's verdict. A negative verdict causes that frame to be repeated, and a verdict that never arrives is ended by a timer.

Every byte on the link has a fixed layout. A 3-bit type field sits above a 4-bit payload, and the top bit makes the count of ones in the byte odd. The sequencer sends bytes to a transmitter and takes reply bytes from a receiver, both over valid/ready handshakes. A single start strobe supplies the opcode, group, entry, value count and data nibbles. A result code is returned with a one-cycle completion pulse.

Top module: `link_write_master`

## Requirements
- R1: Every transmitted byte has the type in bits 6..4 (0 = control, 1 = parameter, 3 = data), the payload in bits 3..0, and bit 7 chosen so that the whole byte has an odd number of ones. The control payloads are: 1 start-of-header, 2 start-of-data, 3 end-of-data, 4 end-of-transmission, 5 negative reply, 6 positive reply, 7 interrupt request.
- R2: A transaction begins with the interrupt-request byte. While the reply is negative, that byte is sent again.
- R3: After a positive reply to the request, the header goes out in this order: start-of-header, then parameter bytes carrying the opcode, group bits 7..4, group bits 3..0, entry, count bits 7..4 and count bits 3..0, then a data-type checksum equal to the modulo-16 sum of those six payloads.
- R4: After a positive reply to the header, the data block goes out in this order: start-of-data, one data byte per nibble (nibble 0 = `data_nibs[3:0]` first), end-of-data, then a data-type checksum equal to the modulo-16 sum of the data nibbles plus 3. A requested count above `DATA_MAX` is treated as `DATA_MAX`, in both the header and the block.
- R5: A positive reply to the data block is followed by the end-of-transmission byte and result 0 (success).
- R6: A negative reply resends the current frame from its opening byte. Each frame may be retried up to `MAX_RETRY` times, and the count restarts for every frame. The next negative reply after that sends end-of-transmission and gives result 1 (failure).
- R7: A reply byte that is not exactly a correctly encoded positive reply is handled as a negative reply. This includes a byte with bad parity and any other control code.
- R8: If no reply has been accepted in the first `TIMEOUT` waiting cycles, end-of-transmission is sent and the result is 2 (timeout). A reply that arrives in the last of those cycles is still accepted.
- R9: `rx_ready` is high only while a reply is awaited, and never together with `tx_valid`. A byte offered on `tx_byte` stays unchanged until it is accepted.
- R10: `start` is accepted only while `busy` is low, and a start pulse during a transaction has no effect on it. `busy` is high from the cycle after an accepted start until completion.
- R11: After reset, `tx_valid`, `rx_ready`, `busy` and `done` are low and `status` is 0.
- R12: `done` is a one-cycle pulse in the cycle after end-of-transmission is accepted. `status` then holds the result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| op_code | input | 4 | Operation code sent in the first parameter byte |
| group_id | input | 8 | Target group, sent as two nibbles |
| entry_id | input | 4 | Target entry within the group |
| data_count | input | 8 | Number of data nibbles, clamped to DATA_MAX |
| data_nibs | input | DATA_MAX*4 | Data nibbles, nibble 0 in the lowest bits |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| tx_byte | output | 8 | Offered byte |
| rx_valid | input | 1 | Receiver holds a reply byte |
| rx_byte | input | 8 | Reply byte |
| rx_ready | output | 1 | Sequencer takes the reply byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result: 0 success, 1 retries exhausted, 2 timeout |

## Verification
The sequencer's position inside a frame and its running checksum can be seen directly in the byte stream. A wrong index or a wrong accumulator value changes the very next byte accepted by the transmitter, and at the latest the frame's closing checksum. A retry counter that is off by one only shows when a frame ends: one frame too many or too few is transmitted before end-of-transmission, and the result code changes. A waiting timer that is off by one makes end-of-transmission appear one cycle early or late, and the bench measures this by counting the cycles in which `rx_ready` was high.

// File: rtl/linkseq_pkg.sv
package linkseq_pkg;

  typedef enum logic [1:0] {PH_INT, PH_HDR, PH_DAT} phase_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT, ST_CLOSE} state_t;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_FAIL = 2'd1, RES_TIMEOUT = 2'd2} result_t;

  localparam logic [2:0] TY_CTRL  = 3'd0;
  localparam logic [2:0] TY_PARAM = 3'd1;
  localparam logic [2:0] TY_DATA  = 3'd3;

  localparam logic [3:0] C_SOH = 4'd1;
  localparam logic [3:0] C_STX = 4'd2;
  localparam logic [3:0] C_ETX = 4'd3;
  localparam logic [3:0] C_EOT = 4'd4;
  localparam logic [3:0] C_ACK = 4'd6;
  localparam logic [3:0] C_INT = 4'd7;

  // Top bit makes the total number of ones odd.
  function automatic logic [7:0] pack_byte(input logic [2:0] ty, input logic [3:0] pl);
    return {~(^{ty, pl}), ty, pl};
  endfunction

endpackage

// File: rtl/linkseq_frame_builder.sv
module linkseq_frame_builder import linkseq_pkg::*; #(
  parameter int DATA_MAX = 16,
  parameter int IDX_W    = 5
) (
  input  phase_t                phase,
  input  logic                  closing,
  input  logic [IDX_W-1:0]      idx,
  input  logic [IDX_W-1:0]      dlen,
  input  logic [3:0]            op,
  input  logic [7:0]            grp,
  input  logic [3:0]            entry,
  input  logic [7:0]            cnt8,
  input  logic [DATA_MAX*4-1:0] nibs,
  input  logic [3:0]            csum,
  output logic [7:0]            frame_byte
);

  localparam int SEL_W = (DATA_MAX > 1) ? $clog2(DATA_MAX) : 1;

  logic [3:0]       nib_arr [DATA_MAX];
  logic [SEL_W-1:0] sel;

  for (genvar g = 0; g < DATA_MAX; g++) begin : g_nib
    assign nib_arr[g] = nibs[g*4 +: 4];
  end

  assign sel = SEL_W'(idx - 1'b1);

  always_comb begin
    frame_byte = pack_byte(TY_CTRL, C_EOT);
    if (!closing) begin
      unique case (phase)
        PH_INT: frame_byte = pack_byte(TY_CTRL, C_INT);
        PH_HDR: begin
          case (idx)
            IDX_W'(0): frame_byte = pack_byte(TY_CTRL,  C_SOH);
            IDX_W'(1): frame_byte = pack_byte(TY_PARAM, op);
            IDX_W'(2): frame_byte = pack_byte(TY_PARAM, grp[7:4]);
            IDX_W'(3): frame_byte = pack_byte(TY_PARAM, grp[3:0]);
            IDX_W'(4): frame_byte = pack_byte(TY_PARAM, entry);
            IDX_W'(5): frame_byte = pack_byte(TY_PARAM, cnt8[7:4]);
            IDX_W'(6): frame_byte = pack_byte(TY_PARAM, cnt8[3:0]);
            default:   frame_byte = pack_byte(TY_DATA,  csum);
          endcase
        end
        default: begin
          if (idx == '0)
            frame_byte = pack_byte(TY_CTRL, C_STX);
          else if (idx <= dlen)
            frame_byte = pack_byte(TY_DATA, nib_arr[sel]);
          else if (idx == dlen + IDX_W'(1))
            frame_byte = pack_byte(TY_CTRL, C_ETX);
          else
            frame_byte = pack_byte(TY_DATA, csum);
        end
      endcase
    end
  end

endmodule

// File: rtl/linkseq_reply_check.sv
module linkseq_reply_check import linkseq_pkg::*; (
  input  logic [7:0] reply,
  output logic       is_ack
);

  logic       par_ok;
  logic [2:0] ty;
  logic [3:0] code;

  assign par_ok = ^reply;
  assign ty     = reply[6:4];
  assign code   = reply[3:0];
  assign is_ack = par_ok && (ty == TY_CTRL) && (code == C_ACK);

endmodule

// File: rtl/linkseq_reply_timer.sv
module linkseq_reply_timer #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);

  localparam int TW = $clog2(TIMEOUT + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (!expired)
      cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == TW'(TIMEOUT - 1));

endmodule

// File: rtl/link_write_master.sv
module link_write_master import linkseq_pkg::*; #(
  parameter int DATA_MAX  = 16,
  parameter int TIMEOUT   = 1024,
  parameter int MAX_RETRY = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [3:0]            op_code,
  input  logic [7:0]            group_id,
  input  logic [3:0]            entry_id,
  input  logic [7:0]            data_count,
  input  logic [DATA_MAX*4-1:0] data_nibs,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_byte,
  input  logic                  rx_valid,
  input  logic [7:0]            rx_byte,
  output logic                  rx_ready,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            status
);

  localparam int IDX_RAW = $clog2(DATA_MAX + 3);
  localparam int IDX_W   = (IDX_RAW < 3) ? 3 : IDX_RAW;
  localparam int RW      = $clog2(MAX_RETRY + 2);

  state_t                state;
  phase_t                phase;
  result_t               res_q;
  logic [IDX_W-1:0]      idx, last_idx, dlen;
  logic [3:0]            csum;
  logic [RW-1:0]         tries;
  logic                  done_q;
  logic [3:0]            op_q, entry_q;
  logic [7:0]            grp_q, cnt8_q;
  logic [DATA_MAX*4-1:0] nibs_q;
  logic [7:0]            cnt_clamped;
  logic                  fire, reply_ack, expired;

  assign cnt_clamped = (data_count > 8'(DATA_MAX)) ? 8'(DATA_MAX) : data_count;
  assign dlen        = IDX_W'(cnt8_q);
  assign tx_valid    = (state == ST_SEND) || (state == ST_CLOSE);
  assign rx_ready    = (state == ST_WAIT);
  assign busy        = (state != ST_IDLE);
  assign done        = done_q;
  assign status      = res_q;
  assign fire        = tx_valid && tx_ready;

  always_comb begin
    unique case (phase)
      PH_INT:  last_idx = '0;
      PH_HDR:  last_idx = IDX_W'(7);
      default: last_idx = dlen + IDX_W'(2);
    endcase
  end

  linkseq_frame_builder #(.DATA_MAX(DATA_MAX), .IDX_W(IDX_W)) u_build (
    .phase(phase), .closing(state == ST_CLOSE), .idx(idx), .dlen(dlen),
    .op(op_q), .grp(grp_q), .entry(entry_q), .cnt8(cnt8_q), .nibs(nibs_q),
    .csum(csum), .frame_byte(tx_byte)
  );

  linkseq_reply_check u_reply (.reply(rx_byte), .is_ack(reply_ack));

  linkseq_reply_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= PH_INT;
      res_q   <= RES_OK;
      idx     <= '0;
      csum    <= '0;
      tries   <= '0;
      done_q  <= 1'b0;
      op_q    <= '0;
      entry_q <= '0;
      grp_q   <= '0;
      cnt8_q  <= '0;
      nibs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q    <= op_code;
            entry_q <= entry_id;
            grp_q   <= group_id;
            cnt8_q  <= cnt_clamped;
            nibs_q  <= data_nibs;
            phase   <= PH_INT;
            idx     <= '0;
            tries   <= '0;
            res_q   <= RES_OK;
            state   <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (fire) begin
            csum <= (idx == '0) ? 4'd0 : csum + tx_byte[3:0];
            if (idx == last_idx) state <= ST_WAIT;
            else                 idx   <= idx + 1'b1;
          end
        end
        ST_WAIT: begin
          if (rx_valid) begin
            idx <= '0;
            if (reply_ack) begin
              tries <= '0;
              if (phase == PH_DAT) begin
                res_q <= RES_OK;
                state <= ST_CLOSE;
              end else begin
                phase <= (phase == PH_INT) ? PH_HDR : PH_DAT;
                state <= ST_SEND;
              end
            end else if (tries == RW'(MAX_RETRY)) begin
              res_q <= RES_FAIL;
              state <= ST_CLOSE;
            end else begin
              tries <= tries + 1'b1;
              state <= ST_SEND;
            end
          end else if (expired) begin
            res_q <= RES_TIMEOUT;
            state <= ST_CLOSE;
          end
        end
        default: begin
          if (fire) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/linkseq_checker.sv
module linkseq_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       rx_ready,
  input logic       busy,
  input logic       done
);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
    !(tx_valid && rx_ready));

  p_odd_parity_r1: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (^tx_byte) == 1'b1);

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_eot_before_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(tx_valid && tx_ready && (tx_byte == 8'h04)));

  p_idle_at_done_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !tx_valid));

  p_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !tx_valid && !rx_ready));

endmodule

bind link_write_master linkseq_checker u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_byte(tx_byte), .rx_ready(rx_ready), .busy(busy), .done(done)
);

// File: tb/tb_link_write_master.sv
module tb_link_write_master;

  localparam int DMAX = 16;
  localparam int TMO  = 20;
  localparam int MAXR = 3;

  localparam int A_ACK = 0, A_NAK = 1, A_BADPAR = 2, A_OTHER = 3, A_SIL = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [3:0]      op_code = '0;
  logic [7:0]      group_id = '0;
  logic [3:0]      entry_id = '0;
  logic [7:0]      data_count = '0;
  logic [DMAX*4-1:0] data_nibs = '0;
  logic            tx_valid;
  logic            tx_ready = 1'b0;
  logic [7:0]      tx_byte;
  logic            rx_valid = 1'b0;
  logic [7:0]      rx_byte = '0;
  logic            rx_ready;
  logic            busy;
  logic            done;
  logic [1:0]      status;

  always #4 clk = ~clk;

  link_write_master #(.DATA_MAX(DMAX), .TIMEOUT(TMO), .MAX_RETRY(MAXR)) dut (
    .clk(clk), .rst(rst), .start(start), .op_code(op_code), .group_id(group_id),
    .entry_id(entry_id), .data_count(data_count), .data_nibs(data_nibs),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .busy(busy), .done(done), .status(status)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int script [0:15];
  logic [7:0] expb [0:511];
  logic [7:0] got  [0:511];
  int nexp, ngot;

  function automatic logic [7:0] enc(input int ty, input int pl);
    logic [6:0] low;
    low = {3'(ty), 4'(pl)};
    return {~(^low), low};
  endfunction

  function automatic logic [7:0] rbyte(input int code);
    case (code)
      A_ACK:    return 8'h86;
      A_NAK:    return 8'h85;
      A_BADPAR: return 8'h06;
      default:  return 8'h07;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic put(input logic [7:0] b);
    expb[nexp] = b;
    nexp++;
  endtask

  task automatic set_script(input int a0, input int a1, input int a2, input int a3,
                            input int a4, input int a5, input int a6);
    for (int i = 0; i < 16; i++) script[i] = A_SIL;
    script[0] = a0; script[1] = a1; script[2] = a2; script[3] = a3;
    script[4] = a4; script[5] = a5; script[6] = a6;
  endtask

  task automatic push_frame(input int ph, input logic [3:0] op, input logic [7:0] grp,
                            input logic [3:0] ent, input int cnt, input logic [63:0] d);
    int s;
    int p [6];
    s = 0;
    if (ph == 0) put(enc(0, 7));
    else if (ph == 1) begin
      p[0] = op; p[1] = grp[7:4]; p[2] = grp[3:0]; p[3] = ent; p[4] = cnt / 16; p[5] = cnt % 16;
      put(enc(0, 1));
      for (int k = 0; k < 6; k++) begin put(enc(1, p[k])); s += p[k]; end
      put(enc(3, s % 16));
    end else begin
      put(enc(0, 2));
      for (int j = 0; j < cnt; j++) begin put(enc(3, d[j*4 +: 4])); s += d[j*4 +: 4]; end
      put(enc(0, 3));
      s += 3;
      put(enc(3, s % 16));
    end
  endtask

  // Protocol model: builds the expected byte stream and result from the reply script.
  task automatic model(input logic [3:0] op, input logic [7:0] grp, input logic [3:0] ent,
                       input int cnt, input logic [63:0] d, output int res);
    int ph, tries, r;
    ph = 0; tries = 0; r = 0; nexp = 0; res = 0;
    while (1) begin
      push_frame(ph, op, grp, ent, cnt, d);
      if (script[r] == A_SIL) begin put(enc(0, 4)); res = 2; break; end
      if (script[r] == A_ACK) begin
        r++;
        tries = 0;
        if (ph == 2) begin put(enc(0, 4)); res = 0; break; end
        ph++;
      end else begin
        r++;
        if (tries == MAXR) begin put(enc(0, 4)); res = 1; break; end
        tries++;
      end
    end
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic [7:0] grp,
                     input logic [3:0] ent, input int cnt_in, input logic [63:0] d,
                     input int delay, input int rmode, input bit poke, input bit tmo_chk);
    int ecnt, eres, r, wcnt, lastw, first_bad;
    bit fin, overlap, hold_bad, pend;
    logic [7:0] pend_byte;
    ecnt = (cnt_in > DMAX) ? DMAX : cnt_in;
    model(op, grp, ent, ecnt, d, eres);
    @(negedge clk);
    op_code = op; group_id = grp; entry_id = ent; data_count = 8'(cnt_in); data_nibs = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", {tag, " busy after start"}, busy, 1);
    ngot = 0; r = 0; wcnt = 0; lastw = 0; fin = 0; overlap = 0; hold_bad = 0; pend = 0;
    pend_byte = '0;
    while (!fin) begin
      if (pend && (!tx_valid || tx_byte != pend_byte)) hold_bad = 1;
      if (tx_valid && rx_ready) overlap = 1;
      if (rx_valid) rx_valid = 1'b0;
      else if (rx_ready) begin
        if (wcnt == delay && script[r] != A_SIL) begin
          rx_byte = rbyte(script[r]); rx_valid = 1'b1; r++; wcnt = 0;
        end else wcnt++;
      end else if (wcnt != 0) begin
        lastw = wcnt; wcnt = 0;
      end
      tx_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 0);
      pend = tx_valid && !tx_ready;
      pend_byte = tx_byte;
      if (tx_valid && tx_ready) begin got[ngot] = tx_byte; ngot++; end
      if (poke && ngot == 3) begin start = 1'b1; op_code = ~op; data_count = 8'd1; end
      else start = 1'b0;
      if (done) fin = 1;
      else @(negedge clk);
    end
    start = 1'b0;
    check(status == 2'(eres), tag, "result code", status, eres);
    check(ngot == nexp, tag, "stream length", ngot, nexp);
    first_bad = -1;
    for (int i = 0; i < nexp && i < ngot; i++)
      if (first_bad < 0 && got[i] != expb[i]) first_bad = i;
    if (first_bad >= 0)
      check(0, {"R1/", tag}, $sformatf("byte %0d", first_bad), got[first_bad], expb[first_bad]);
    else
      check(1, {"R1/", tag}, "bytes", 0, 0);
    check(!overlap && !hold_bad, "R9", {tag, " handshake rules"}, {overlap, hold_bad}, 0);
    if (tmo_chk) check(lastw == TMO, "R8", {tag, " waiting cycles"}, lastw, TMO);
    @(negedge clk);
    check(!busy && !tx_valid && !done && status == 2'(eres), "R12",
          {tag, " idle after done"}, {busy, tx_valid, done, status}, eres);
  endtask

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_valid && !rx_ready && !busy && !done && status == 2'd0, "R11", "reset state",
          {tx_valid, rx_ready, busy, done, status}, 0);

    // R4/R5 sweep over every data count with positive replies
    for (int c = 0; c <= DMAX; c++) begin
      for (int j = 0; j < 16; j++) d[j*4 +: 4] = 4'(c * 5 + j * 7 + 3);
      set_script(A_ACK, A_ACK, A_ACK, A_SIL, A_SIL, A_SIL, A_SIL);
      run("R4", 4'(c + 1), 8'(c * 17 + 9), 4'(15 - c), c, d, c % 4, c % 2, 0, 0);
    end
    d = 64'hFEDC_BA98_7654_3210;
    // R2: request repeated after negative replies
    set_script(A_NAK, A_NAK, A_ACK, A_ACK, A_ACK, A_SIL, A_SIL);
    run("R2", 4'hA, 8'h5C, 4'h3, 4, d, 1, 0, 0, 0);
    // R3/R6: header retried the maximum number of times, then accepted
    set_script(A_ACK, A_NAK, A_NAK, A_NAK, A_ACK, A_ACK, A_SIL);
    run("R3", 4'h2, 8'hF1, 4'h9, 6, d, 0, 1, 0, 0);
    // R6: request refused past the limit
    set_script(A_NAK, A_NAK, A_NAK, A_NAK, A_SIL, A_SIL, A_SIL);
    run("R6", 4'h1, 8'h00, 4'h0, 2, d, 0, 0, 0, 0);
    // R6: data block refused past the limit, retry count restarted per frame
    set_script(A_ACK, A_ACK, A_NAK, A_NAK, A_NAK, A_NAK, A_SIL);
    run("R6", 4'h7, 8'h3E, 4'hD, 3, d, 2, 1, 0, 0);
    // R7: malformed replies count as negative
    set_script(A_BADPAR, A_OTHER, A_ACK, A_ACK, A_ACK, A_SIL, A_SIL);
    run("R7", 4'h5, 8'hA5, 4'h6, 5, d, 0, 0, 0, 0);
    set_script(A_ACK, A_OTHER, A_BADPAR, A_OTHER, A_BADPAR, A_SIL, A_SIL);
    run("R7", 4'h5, 8'hA5, 4'h6, 5, d, 0, 0, 0, 0);
    // R8: silence on the request, silence on the data block, late reply accepted
    set_script(A_SIL, A_SIL, A_SIL, A_SIL, A_SIL, A_SIL, A_SIL);
    run("R8", 4'h3, 8'h11, 4'h2, 1, d, 0, 0, 0, 1);
    set_script(A_ACK, A_ACK, A_SIL, A_SIL, A_SIL, A_SIL, A_SIL);
    run("R8", 4'h3, 8'h11, 4'h2, 7, d, 0, 1, 0, 1);
    set_script(A_ACK, A_ACK, A_ACK, A_SIL, A_SIL, A_SIL, A_SIL);
    run("R8", 4'hC, 8'h90, 4'h4, 2, d, TMO - 1, 0, 0, 0);
    // R4: oversized count is clamped
    set_script(A_ACK, A_ACK, A_ACK, A_SIL, A_SIL, A_SIL, A_SIL);
    run("R4", 4'hE, 8'h7B, 4'h1, 200, d, 0, 0, 0, 0);
    // R10: start pulse during a transaction is ignored
    set_script(A_ACK, A_ACK, A_ACK, A_SIL, A_SIL, A_SIL, A_SIL);
    run("R10", 4'h9, 8'h42, 4'h8, 9, d, 1, 0, 1, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule